// File: doc/BRIEF.md
# Pipelined Coherent Burst SRAM

A single-bank synchronous memory with one single-data-rate command port. In each clock cycle the port may carry one of three commands: a read, a write, or a configuration-register write. Every memory access moves a burst of two words. The first word goes to or comes from the commanded address. The second word belongs to its partner address, which is the same address with its least significant bit inverted.

Write data arrives with no latency. The first beat is sampled together with the write command, and the second beat is sampled in the following cycle. Read data leaves through a fixed-latency pipeline. The first beat appears five cycles after the read is accepted, and the second beat follows in the next cycle. Writes are posted into a short queue before they reach the array. To keep reads coherent, every read compares its address against all queued writes and against the write beat arriving in the same cycle. The youngest match supplies the data.

A latency-mode bit comes out of reset set, and reads are refused until software clears it. The bit is written through the address lines. The data path has no back-pressure. There is no ready signal, and the consumer must take each `rvalid` beat in the cycle it is presented. Issue rules on the command port take the place of stalls: a read may not directly follow an accepted read, and a write may not directly follow an accepted write.

Top module: `coh_burst_sram`

## Requirements
- R1: During and after reset, `rvalid` and `rd_err` are 0 and `lat_mode` is 1.
- R2: A write command accepted at clock edge k stores `wdata` sampled at edge k into address A. It stores `wdata` sampled at edge k+1 into address A with bit 0 inverted.
- R3: A read accepted at edge k holds `rvalid` high in the two cycles that follow edges k+5 and k+6. `rdata` carries the word at address A in the first of those cycles and the word at A with bit 0 inverted in the second.
- R4: A read returns the newest data for each of its two addresses. This includes write beats still in the posted queue and the second beat of a write commanded in the cycle just before the read.
- R5: A register write with `addr[5:4]` = 0 loads `addr[0]` into `lat_mode`, and `addr[3:1]` are ignored. A register write with any other value in `addr[5:4]` leaves `lat_mode` unchanged.
- R6: A read issued while `lat_mode` is 1 produces no `rvalid` beats. `rd_err` is high for the one cycle after edge k, where k is the edge that sampled the read.
- R7: A cycle with more than one of `cmd_rd`, `cmd_wr` and `cmd_reg` high is ignored. It writes no memory, returns no data, does not change `lat_mode` and does not raise `rd_err`.
- R8: A read in the cycle directly after an accepted read is dropped. A write in the cycle directly after an accepted write is dropped, because the data bus in that cycle carries the second beat of the earlier write.
- R9: When several writes to one address are in flight together, a read returns the data of the most recent one.
- R10: A write commanded after a read does not alter the data that read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_reg | input | 1 | Register-write command |
| addr | input | ADDR_W (6) | Word address. For register writes: [5:4] register number, [0] data |
| wdata | input | DATA_W (16) | Write data: beat 0 with the command, beat 1 in the next cycle |
| rdata | output | DATA_W (16) | Read data beats |
| rvalid | output | 1 | High for each read data beat |
| rd_err | output | 1 | One-cycle flag for a read refused because the latency mode is set |
| lat_mode | output | 1 | Current value of the latency-mode bit |

## Verification
A bad forwarding match or a wrong priority order in the posted-write queue would not show up as a missing beat. It would show up as stale data in one `rdata` beat, exactly five or six cycles after a read that closely follows a write. Because of this, the stimulus deliberately packs reads and writes to the same and partner addresses into back-to-back cycles. A read pipeline that is too short or too long shifts `rvalid` by whole cycles, and the bench catches this on the first read after the mode bit clears. A faulty issue-rule or decode register makes beats vanish or overlap within two cycles. A wrong mode-bit value appears directly on `lat_mode` and `rd_err` one cycle after the command.

// File: rtl/csram_pkg.sv
package csram_pkg;
  // Command classes after one-hot legality check
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_REG   = 2'd3
  } op_e;

  // Register number that holds the latency-mode bit
  localparam int REG_LATMODE = 0;
  // Value of the latency-mode bit out of reset (reads refused)
  localparam logic LATMODE_RESET = 1'b1;
endpackage

// File: rtl/csram_cmd.sv
module csram_cmd
  import csram_pkg::*;
#(
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_reg,
  input  logic [RSEL_W-1:0] reg_sel,
  input  logic              reg_bit,
  output logic              rd_go,
  output logic              wr_go,
  output logic              rd_err,
  output logic              lat_mode
);
  op_e  op;
  logic prev_rd;
  logic prev_wr;
  logic rd_blocked;

  // Exactly one command line selects an operation; anything else is void
  always_comb begin
    case ({cmd_rd, cmd_wr, cmd_reg})
      3'b100:  op = OP_READ;
      3'b010:  op = OP_WRITE;
      3'b001:  op = OP_REG;
      default: op = OP_NONE;
    endcase
  end

  // Data-bus occupancy rules: a burst owns its bus for two cycles
  assign rd_blocked = (op == OP_READ) && !prev_rd && lat_mode;
  assign rd_go      = (op == OP_READ) && !prev_rd && !lat_mode;
  assign wr_go      = (op == OP_WRITE) && !prev_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rd  <= 1'b0;
      prev_wr  <= 1'b0;
      rd_err   <= 1'b0;
      lat_mode <= LATMODE_RESET;
    end else begin
      prev_rd <= rd_go;
      prev_wr <= wr_go;
      rd_err  <= rd_blocked;
      if (op == OP_REG && reg_sel == RSEL_W'(REG_LATMODE))
        lat_mode <= reg_bit;
    end
  end
endmodule

// File: rtl/csram_array.sv
module csram_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Two asynchronous read ports: one per burst beat
  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/csram_wqueue.sv
module csram_wqueue #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] look0,
  input  logic [ADDR_W-1:0] look1,
  output logic              hit0,
  output logic [DATA_W-1:0] hdata0,
  output logic              hit1,
  output logic [DATA_W-1:0] hdata1,
  output logic              cm_en,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data
);
  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] PARTNER = ADDR_W'(1);

  logic              b1_pend;
  logic [ADDR_W-1:0] b1_addr;
  logic              in_v;
  logic [ADDR_W-1:0] in_a;
  logic              q_v [DEPTH];
  logic [ADDR_W-1:0] q_a [DEPTH];
  logic [DATA_W-1:0] q_d [DEPTH];
  logic [ADDR_W-1:0] look [NPORT];

  // Beat entering this cycle: first beat of a new write or second of the last
  assign in_v = wr_go | b1_pend;
  assign in_a = wr_go ? addr : b1_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1_pend <= 1'b0;
    end else begin
      b1_pend <= wr_go;
    end
  end

  always_ff @(posedge clk) begin
    b1_addr <= addr ^ PARTNER;
  end

  // Posted-write shift queue: slot 0 youngest, slot DEPTH-1 retires to array
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q_v[i] <= 1'b0;
    end else begin
      q_v[0] <= in_v;
      for (int i = 1; i < DEPTH; i++) q_v[i] <= q_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    q_a[0] <= in_a;
    q_d[0] <= wdata;
    for (int i = 1; i < DEPTH; i++) begin
      q_a[i] <= q_a[i-1];
      q_d[i] <= q_d[i-1];
    end
  end

  assign cm_en   = q_v[DEPTH-1];
  assign cm_addr = q_a[DEPTH-1];
  assign cm_data = q_d[DEPTH-1];

  assign look[0] = look0;
  assign look[1] = look1;

  // One forwarding comparator chain per burst beat; youngest match wins
  for (genvar p = 0; p < NPORT; p++) begin : g_fwd
    logic              hit;
    logic [DATA_W-1:0] hdat;
    always_comb begin
      hit  = 1'b0;
      hdat = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (q_v[i] && q_a[i] == look[p]) begin
          hit  = 1'b1;
          hdat = q_d[i];
        end
      end
      if (in_v && in_a == look[p]) begin
        hit  = 1'b1;
        hdat = wdata;
      end
    end
  end

  assign hit0   = g_fwd[0].hit;
  assign hdata0 = g_fwd[0].hdat;
  assign hit1   = g_fwd[1].hit;
  assign hdata1 = g_fwd[1].hdat;
endmodule

// File: rtl/csram_rdpipe.sv
module csram_rdpipe #(
  parameter int DATA_W = 16,
  parameter int LAT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [DATA_W-1:0] in_d0,
  input  logic [DATA_W-1:0] in_d1,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  // Stages 0..LAT-1 are loaded on edges k..k+LAT-1; output register on k+LAT
  localparam int STAGES = LAT;

  logic              pv  [STAGES];
  logic [DATA_W-1:0] pd0 [STAGES];
  logic [DATA_W-1:0] pd1 [STAGES];
  logic              tail_v;
  logic [DATA_W-1:0] tail_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pv[i] <= 1'b0;
    end else begin
      pv[0] <= in_v;
      for (int i = 1; i < STAGES; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pd0[0] <= in_d0;
    pd1[0] <= in_d1;
    for (int i = 1; i < STAGES; i++) begin
      pd0[i] <= pd0[i-1];
      pd1[i] <= pd1[i-1];
    end
  end

  // Burst serializer: first beat from the last stage, second beat one cycle on
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      tail_v <= 1'b0;
      rdata  <= '0;
      tail_d <= '0;
    end else if (pv[STAGES-1]) begin
      rvalid <= 1'b1;
      rdata  <= pd0[STAGES-1];
      tail_v <= 1'b1;
      tail_d <= pd1[STAGES-1];
    end else if (tail_v) begin
      rvalid <= 1'b1;
      rdata  <= tail_d;
      tail_v <= 1'b0;
    end else begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_burst_sram.sv
module coh_burst_sram #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int RD_LAT   = 5,
  parameter int WQ_DEPTH = 3,
  parameter int RSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_reg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              rd_err,
  output logic              lat_mode
);
  localparam logic [ADDR_W-1:0] PARTNER = ADDR_W'(1);

  logic              rd_go;
  logic              wr_go;
  logic [ADDR_W-1:0] ra0;
  logic [ADDR_W-1:0] ra1;
  logic [DATA_W-1:0] arr0;
  logic [DATA_W-1:0] arr1;
  logic              hit0;
  logic              hit1;
  logic [DATA_W-1:0] fwd0;
  logic [DATA_W-1:0] fwd1;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic [DATA_W-1:0] snap0;
  logic [DATA_W-1:0] snap1;

  csram_cmd #(.RSEL_W(RSEL_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_reg  (cmd_reg),
    .reg_sel  (addr[ADDR_W-1 -: RSEL_W]),
    .reg_bit  (addr[0]),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .rd_err   (rd_err),
    .lat_mode (lat_mode)
  );

  assign ra0 = addr;
  assign ra1 = addr ^ PARTNER;

  csram_wqueue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WQ_DEPTH)) u_wq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .addr    (addr),
    .wdata   (wdata),
    .look0   (ra0),
    .look1   (ra1),
    .hit0    (hit0),
    .hdata0  (fwd0),
    .hit1    (hit1),
    .hdata1  (fwd1),
    .cm_en   (cm_en),
    .cm_addr (cm_addr),
    .cm_data (cm_data)
  );

  csram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk    (clk),
    .we     (cm_en),
    .waddr  (cm_addr),
    .wdata  (cm_data),
    .raddr0 (ra0),
    .raddr1 (ra1),
    .rdata0 (arr0),
    .rdata1 (arr1)
  );

  // Snapshot both beats at command time; in-flight writes override the array
  assign snap0 = hit0 ? fwd0 : arr0;
  assign snap1 = hit1 ? fwd1 : arr1;

  csram_rdpipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_rp (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_v   (rd_go),
    .in_d0  (snap0),
    .in_d1  (snap1),
    .rvalid (rvalid),
    .rdata  (rdata)
  );
endmodule

// File: rtl/csram_chk.sv
module csram_chk #(
  parameter int RD_LAT = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_rd,
  input logic cmd_wr,
  input logic cmd_reg,
  input logic rvalid,
  input logic rd_err,
  input logic lat_mode,
  input logic rd_go,
  input logic wr_go
);
  // hist[j] seen at an edge = read acceptance j+1 edges earlier
  logic [RD_LAT+1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[RD_LAT:0], rd_go};
  end

  a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    hist[RD_LAT] |-> rvalid);
  a_r3_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    hist[RD_LAT+1] |-> rvalid);
  a_r3_no_stray_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (hist[RD_LAT] || hist[RD_LAT+1]));
  a_r8_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
  a_r8_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);
  a_r6_mode_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    lat_mode |-> !rd_go);
  a_r7_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({cmd_rd, cmd_wr, cmd_reg}) > 1) |-> (!rd_go && !wr_go));
  a_r7_illegal_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({cmd_rd, cmd_wr, cmd_reg}) > 1) |=> ($stable(lat_mode) && !rd_err));
endmodule

bind coh_burst_sram csram_chk #(.RD_LAT(RD_LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_rd   (cmd_rd),
  .cmd_wr   (cmd_wr),
  .cmd_reg  (cmd_reg),
  .rvalid   (rvalid),
  .rd_err   (rd_err),
  .lat_mode (lat_mode),
  .rd_go    (rd_go),
  .wr_go    (wr_go)
);

// File: tb/coh_burst_sram_tb.sv
`timescale 1ns/1ps
module coh_burst_sram_tb;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LAT = 5;
  localparam int RING = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_rd = 1'b0;
  logic          cmd_wr = 1'b0;
  logic          cmd_reg = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;
  logic          rd_err;
  logic          lat_mode;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit running = 1'b0;
  string phase = "R1";

  // Reference model state
  logic [DW-1:0] m_mem [1 << AW];
  bit            m_lat;
  bit            m_prd;
  bit            m_pwr;
  bit            m_pend;
  logic [AW-1:0] m_pa;
  bit            ev [RING];
  logic [DW-1:0] ed [RING];
  string         et [RING];
  bit            ee [RING];

  always #2 clk = ~clk;

  coh_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_reg(cmd_reg), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid), .rd_err(rd_err), .lat_mode(lat_mode)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Expected data for address a as a function of a seed
  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 16'h0137) ^ (s * 16'h2c49) ^ 16'h5a00);
  endfunction

  // Model: architectural view, writes visible at once, read snapshot at command
  always @(posedge clk) begin
    int n;
    bit acc_r;
    bit acc_w;
    cyc++;
    acc_r = 1'b0;
    acc_w = 1'b0;
    n = int'(cmd_rd) + int'(cmd_wr) + int'(cmd_reg);
    if (!rst_n) begin
      m_lat  = 1'b1;
      m_prd  = 1'b0;
      m_pwr  = 1'b0;
      m_pend = 1'b0;
      for (int i = 0; i < RING; i++) begin
        ev[i] = 1'b0;
        ee[i] = 1'b0;
      end
    end else begin
      if (m_pend) begin
        m_mem[m_pa] = wdata;
        m_pend = 1'b0;
      end
      if (n == 1 && cmd_rd && !m_prd) begin
        if (m_lat) begin
          ee[cyc % RING] = 1'b1;
        end else begin
          ev[(cyc + LAT) % RING]     = 1'b1;
          ed[(cyc + LAT) % RING]     = m_mem[addr];
          et[(cyc + LAT) % RING]     = phase;
          ev[(cyc + LAT + 1) % RING] = 1'b1;
          ed[(cyc + LAT + 1) % RING] = m_mem[addr ^ AW'(1)];
          et[(cyc + LAT + 1) % RING] = phase;
          acc_r = 1'b1;
        end
      end
      if (n == 1 && cmd_wr && !m_pwr) begin
        m_mem[addr] = wdata;
        m_pend = 1'b1;
        m_pa = addr ^ AW'(1);
        acc_w = 1'b1;
      end
      if (n == 1 && cmd_reg && addr[5:4] == 2'd0) m_lat = addr[0];
      m_prd = acc_r;
      m_pwr = acc_w;
    end
  end

  // Port comparison away from the active edge
  always @(negedge clk) begin
    int ix;
    if (running && rst_n) begin
      ix = cyc % RING;
      chk(rvalid == ev[ix], ev[ix] ? et[ix] : phase, "rvalid", rvalid, ev[ix]);
      if (ev[ix]) chk(rdata == ed[ix], et[ix], "rdata", rdata, ed[ix]);
      chk(rd_err == ee[ix], "R6", "rd_err", rd_err, ee[ix]);
      chk(lat_mode == m_lat, "R5", "lat_mode", lat_mode, m_lat);
      ev[ix] = 1'b0;
      ee[ix] = 1'b0;
    end
  end

  task automatic step(input bit r, input bit w, input bit g,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_rd  = r;
    cmd_wr  = w;
    cmd_reg = g;
    addr    = a;
    wdata   = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, DW'($urandom));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finished (cycle %0d)", cyc);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rvalid == 1'b0, "R1", "rvalid in reset", rvalid, 0);
    chk(rd_err == 1'b0, "R1", "rd_err in reset", rd_err, 0);
    chk(lat_mode == 1'b1, "R1", "lat_mode in reset", lat_mode, 1);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    chk(lat_mode == 1'b1, "R1", "lat_mode after reset", lat_mode, 1);

    // R2: preload every location with two-beat bursts
    phase = "R2";
    for (int a = 0; a < (1 << AW); a += 2) begin
      step(0, 1, 0, AW'(a + 1), pat(a + 1, 1));
      step(0, 0, 0, '0, pat(a, 1));
    end

    // R6: read refused while the mode bit is set
    phase = "R6";
    step(1, 0, 0, 6'd4, '0);
    idle(8);

    // R5: other register number ignored, then reg 0 cleared with junk bits
    phase = "R5";
    step(0, 0, 1, 6'b01_000_0, '0);
    idle(1);
    step(0, 0, 1, 6'b00_101_0, '0);
    idle(1);

    // R2 R3: read back preloaded pairs, both orders inside a pair
    phase = "R3";
    step(1, 0, 0, 6'd0, '0);
    idle(1);
    step(1, 0, 0, 6'd9, '0);
    idle(1);
    step(1, 0, 0, 6'd62, '0);
    idle(8);

    // R4: read in the cycle after a write, same and partner address
    phase = "R4";
    step(0, 1, 0, 6'd10, 16'hA0A0);
    step(1, 0, 0, 6'd10, 16'hB1B1);
    idle(2);
    step(0, 1, 0, 6'd12, 16'hC2C2);
    step(1, 0, 0, 6'd13, 16'hD3D3);
    idle(8);

    // R9: two writes to one pair still queued; youngest wins
    phase = "R9";
    step(0, 1, 0, 6'd20, 16'h1111);
    step(0, 0, 0, '0, 16'h2222);
    step(0, 1, 0, 6'd20, 16'h3333);
    step(1, 0, 0, 6'd20, 16'h4444);
    idle(8);

    // R10: write following a read does not leak into it
    phase = "R10";
    step(1, 0, 0, 6'd30, '0);
    step(0, 1, 0, 6'd30, 16'h7777);
    step(0, 0, 0, '0, 16'h8888);
    idle(8);

    // R7: multiple command lines together are void
    phase = "R7";
    step(1, 1, 0, 6'd40, 16'hEEEE);
    step(1, 0, 1, 6'b00_000_1, '0);
    step(0, 1, 1, 6'b00_000_1, 16'hDDDD);
    step(1, 1, 1, 6'd41, 16'hCCCC);
    idle(2);
    step(1, 0, 0, 6'd40, '0);
    idle(8);

    // R8: back-to-back reads and writes, second of each dropped
    phase = "R8";
    step(1, 0, 0, 6'd50, '0);
    step(1, 0, 0, 6'd52, '0);
    idle(2);
    step(0, 1, 0, 6'd54, 16'h5454);
    step(0, 1, 0, 6'd56, 16'h5555);
    idle(2);
    step(1, 0, 0, 6'd56, '0);
    idle(2);
    step(1, 0, 0, 6'd54, '0);
    idle(8);

    // R3 R4: constrained random traffic
    phase = "R4";
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [AW-1:0] a;
      k = int'($urandom % 12);
      a = AW'($urandom);
      if (k < 4)       step(1, 0, 0, a, DW'($urandom));
      else if (k < 8)  step(0, 1, 0, a, DW'($urandom));
      else if (k == 8) step(0, 0, 1, {a[5:1], ($urandom % 8) == 0}, DW'($urandom));
      else if (k == 9) step(1, 1, $urandom % 2, a, DW'($urandom));
      else             step(0, 0, 0, a, DW'($urandom));
    end
    idle(12);
    running = 1'b0;
    summary();
    $finish;
  end
endmodule